// File: doc/BRIEF.md
# Programmable Output-Rate Tick Generator

This block sets the rate at which a bank of pattern channels steps through its stored bits. An 8-bit configuration word picks one of four timing sources: a synchronized external clock pin, the fast reference clock itself, the reference halved by a dedicated toggle stage, or the reference divided by a power of two whose exponent comes from a 5-bit field. The block never gates a clock. Its output is a single-cycle tick enable in the reference clock domain, and downstream logic advances one pattern bit per tick.

An active-low enable bit in the word stops the block. While stopped, no ticks are produced, the output-clock level stays high and a status output reports the idle condition. A follow input lets a secondary unit take its ticks from a master unit's tick, so that several units step in lockstep. While the block follows the master, its local divider is frozen and later resumes from the count it had. Every write to the word restarts the local dividers, so the first local tick after a write comes one full period later. An exponent outside the usable range is clamped to the smallest legal value, and a status output flags it.

The control core is a six-state machine. HALT is the stopped state. EXT, REF, HALF and POW2 are the four local sources. SLAVE is the follow state. Any write moves HALT or a source state to HALT when bit 7 is 1, and otherwise to the source state named by bits 1:0. Without a write, a source state moves to SLAVE while the follow input is high. SLAVE returns to the stored source state once the follow input drops. HALT leaves only on a write.

Top module: `otg_clk_sel`

## Requirements
- R1: After reset the block is stopped: masked_o=1, tick_o=0, out_clk_o=1, range_err_o=0.
- R2: A write with bit 7 = 1 stops the block from the next cycle. It then stays with masked_o=1, tick_o=0 and out_clk_o=1, whatever the external clock, follow and master tick inputs do, until the next write.
- R3: A write with bit 7 = 0 and bits 1:0 = 01 (reference) makes tick_o high on every cycle from the first cycle after the write.
- R4: Bits 1:0 = 10 (half rate) gives tick_o on every second cycle. The first tick falls in the 2nd cycle after the write.
- R5: Bits 1:0 = 11 (power of two) with exponent n in bits 6:2 gives a tick every 2^n cycles. The first tick falls in the 2^n-th cycle after the write.
- R6: An exponent n of 0, 1, 2 or 31 written together with bits 1:0 = 11 is used as n = 3 and sets range_err_o to 1. A write with a legal n (3 to 30), or with any other source code, clears range_err_o.
- R7: Bits 1:0 = 00 (external) gives exactly one single-cycle tick for each rising edge of ext_clk_i. The edge passes through a two-stage synchronizer, and no tick appears without an edge.
- R8: When follow_i is high and the block is not stopped, tick_o equals master_tick_i from the next cycle on. After follow_i drops, the local source takes over again in the next cycle.
- R9: While following, the local divider does not count. When the block returns, the local divider continues from its held count, so the total number of local cycles to the first tick is still one full period.
- R10: out_clk_o is the complement of tick_o. It is low for exactly the cycles that carry a tick and is high when the block is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_data_i | input | 8 | Configuration word: bit 7 stop (active-low enable), bits 6:2 exponent, bits 1:0 source |
| ext_clk_i | input | 1 | Asynchronous external clock pin |
| follow_i | input | 1 | Take ticks from the master instead of the local source |
| master_tick_i | input | 1 | Tick from the master unit, already in the reference domain |
| tick_o | output | 1 | Single-cycle output-rate tick enable |
| out_clk_o | output | 1 | Output-clock level: low during a tick, held high when stopped |
| masked_o | output | 1 | Block is stopped |
| range_err_o | output | 1 | Last write carried an out-of-range exponent for the power-of-two source |

## Verification
The assertions check on every cycle that a stopped block emits nothing and keeps its clock level high, and that the stopped status changes only after a write. They also check that a write always restarts the half-rate and power-of-two sources with a quiet first cycle, that range_err_o cannot be set by a write for another source, and that tick_o mirrors the master tick while following. The exact periods, the phase of the first tick, the clamping of bad exponents, the one-tick-per-edge behaviour of the external path and the resumption of a held divider count are sequence properties, so the bench's directed scenarios show them.

// File: rtl/otg_pkg.sv
package otg_pkg;

    localparam int CFG_W       = 8;
    localparam int STOP_BIT    = 7;
    localparam int EXP_LSB     = 2;
    localparam int EXP_W       = 5;
    localparam int SRC_W       = 2;

    localparam logic [SRC_W-1:0] SRC_EXT  = 2'b00;
    localparam logic [SRC_W-1:0] SRC_REF  = 2'b01;
    localparam logic [SRC_W-1:0] SRC_HALF = 2'b10;
    localparam logic [SRC_W-1:0] SRC_POW2 = 2'b11;

    typedef enum logic [2:0] {
        ST_HALT  = 3'd0,
        ST_EXT   = 3'd1,
        ST_REF   = 3'd2,
        ST_HALF  = 3'd3,
        ST_POW2  = 3'd4,
        ST_SLAVE = 3'd5
    } otg_state_e;

    function automatic otg_state_e src_state(input logic [SRC_W-1:0] src);
        otg_state_e s;
        unique case (src)
            SRC_EXT:  s = ST_EXT;
            SRC_REF:  s = ST_REF;
            SRC_HALF: s = ST_HALF;
            default:  s = ST_POW2;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/otg_sync_edge.sv
module otg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[g] <= 1'b0;
                    else         chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[g] <= 1'b0;
                    else         chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= 1'b0;
        else         last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/otg_half_div.sv
module otg_half_div (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic en_i,
    output logic tick_o
);
    logic phase_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     phase_q <= 1'b0;
        else if (clr_i)  phase_q <= 1'b0;
        else if (en_i)   phase_q <= ~phase_q;
    end

    assign tick_o = phase_q;
endmodule

// File: rtl/otg_pow2_div.sv
module otg_pow2_div #(
    parameter int EXP_W   = 5,
    parameter int EXP_MAX = 30
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);
    localparam int CNT_W = EXP_MAX;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    // 1 << EXP_MAX wraps to zero, and zero minus one is the full count
    assign last_val = (CNT_W'(1) << exp_i) - CNT_W'(1);
    assign tick_o   = (cnt_q == last_val);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (en_i)   cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/otg_clk_sel.sv
module otg_clk_sel
    import otg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EXP_MIN     = 3,
    parameter int EXP_MAX     = 30
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_data_i,
    input  logic             ext_clk_i,
    input  logic             follow_i,
    input  logic             master_tick_i,
    output logic             tick_o,
    output logic             out_clk_o,
    output logic             masked_o,
    output logic             range_err_o
);
    otg_state_e       st_q, st_d;
    logic [SRC_W-1:0] src_q;
    logic [EXP_W-1:0] exp_q;
    logic             err_q;

    logic [EXP_W-1:0] wr_exp;
    logic [SRC_W-1:0] wr_src;
    logic             wr_bad;
    logic             ext_rise, half_tick, pow_tick;

    assign wr_exp = cfg_data_i[EXP_LSB +: EXP_W];
    assign wr_src = cfg_data_i[SRC_W-1:0];
    assign wr_bad = (int'(wr_exp) < EXP_MIN) || (int'(wr_exp) > EXP_MAX);

    // configuration fields
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            src_q <= SRC_EXT;
            exp_q <= EXP_W'(EXP_MIN);
            err_q <= 1'b0;
        end else if (cfg_we_i) begin
            src_q <= wr_src;
            exp_q <= wr_bad ? EXP_W'(EXP_MIN) : wr_exp;
            err_q <= wr_bad && (wr_src == SRC_POW2);
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_HALT;
        else         st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (cfg_we_i) begin
            st_d = cfg_data_i[STOP_BIT] ? ST_HALT : src_state(wr_src);
        end else begin
            unique case (st_q)
                ST_HALT:  st_d = ST_HALT;
                ST_SLAVE: st_d = follow_i ? ST_SLAVE : src_state(src_q);
                ST_EXT, ST_REF, ST_HALF, ST_POW2:
                          st_d = follow_i ? ST_SLAVE : st_q;
                default:  st_d = ST_HALT;
            endcase
        end
    end

    // output logic
    always_comb begin
        unique case (st_q)
            ST_HALT:  tick_o = 1'b0;
            ST_EXT:   tick_o = ext_rise;
            ST_REF:   tick_o = 1'b1;
            ST_HALF:  tick_o = half_tick;
            ST_POW2:  tick_o = pow_tick;
            ST_SLAVE: tick_o = master_tick_i;
            default:  tick_o = 1'b0;
        endcase
        masked_o  = (st_q == ST_HALT);
        out_clk_o = ~tick_o;
    end

    assign range_err_o = err_q;

    otg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_clk_i),
        .rise_o  (ext_rise)
    );

    otg_half_div u_half (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cfg_we_i),
        .en_i   (st_q == ST_HALF),
        .tick_o (half_tick)
    );

    otg_pow2_div #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_pow2 (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cfg_we_i),
        .en_i   (st_q == ST_POW2),
        .exp_i  (exp_q),
        .tick_o (pow_tick)
    );
endmodule

// File: rtl/otg_clk_sel_chk.sv
module otg_clk_sel_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cfg_we_i,
    input logic [7:0] cfg_data_i,
    input logic       follow_i,
    input logic       master_tick_i,
    input logic       tick_o,
    input logic       out_clk_o,
    input logic       masked_o,
    input logic       range_err_o
);
    // R2, R10: stopped means silent with the clock level high
    a_r2_halt_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        masked_o |-> (!tick_o && out_clk_o));

    // R2: the stopped status only moves after a write
    a_r2_mask_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_we_i |=> $stable(masked_o));

    // R4, R5: divided sources restart with a quiet first cycle
    a_r5_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && !cfg_data_i[7] && cfg_data_i[1]) |=> !tick_o);

    // R6: only the power-of-two source can raise the range flag
    a_r6_err_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_data_i[1:0] != 2'b11) |=> !range_err_o);

    // R8: following mirrors the master tick
    a_r8_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!masked_o && follow_i && !cfg_we_i) |=> (tick_o == master_tick_i));

    // R3: reference source ticks on the next cycle
    a_r3_ref_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_data_i[7:0] ==? 8'b0xxxxx01) |=> tick_o);
endmodule

bind otg_clk_sel otg_clk_sel_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_data_i    (cfg_data_i),
    .follow_i      (follow_i),
    .master_tick_i (master_tick_i),
    .tick_o        (tick_o),
    .out_clk_o     (out_clk_o),
    .masked_o      (masked_o),
    .range_err_o   (range_err_o)
);

// File: tb/otg_clk_sel_tb.sv
module otg_clk_sel_tb;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [7:0] cfg_data_i = 8'h00;
    logic       ext_clk_i = 1'b0;
    logic       follow_i = 1'b0;
    logic       master_tick_i = 1'b0;
    logic       tick_o, out_clk_o, masked_o, range_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    otg_clk_sel u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_data_i(cfg_data_i),
        .ext_clk_i(ext_clk_i), .follow_i(follow_i), .master_tick_i(master_tick_i),
        .tick_o(tick_o), .out_clk_o(out_clk_o), .masked_o(masked_o), .range_err_o(range_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // returns at the negedge of the first cycle after the write
    task automatic wr(input logic [7:0] d);
        @(negedge clk_i);
        cfg_we_i = 1'b1; cfg_data_i = d;
        @(negedge clk_i);
        cfg_we_i = 1'b0;
    endtask

    function automatic logic [7:0] cfg(input bit stop, input int n, input int src);
        return {stop, 5'(n), 2'(src)};
    endfunction

    // counts cycles, starting with the current one, until the first tick
    task automatic period_check(input string req, input int period, input int cycles);
        for (int i = 1; i <= cycles; i++) begin
            chk(tick_o == (i % period == 0), req, tick_o, (i % period == 0));
            chk(out_clk_o == !tick_o, "R10", out_clk_o, !tick_o);
            @(negedge clk_i);
        end
    endtask

    task automatic t_reset;
        chk(masked_o == 1'b1, "R1", masked_o, 1);
        chk(tick_o == 1'b0, "R1", tick_o, 0);
        chk(out_clk_o == 1'b1, "R1", out_clk_o, 1);
        chk(range_err_o == 1'b0, "R1", range_err_o, 0);
    endtask

    task automatic t_halt;
        int seen = 0;
        wr(cfg(1, 3, 1));
        follow_i = 1'b1; master_tick_i = 1'b1;
        for (int i = 0; i < 12; i++) begin
            ext_clk_i = (i % 4) < 2;
            if (tick_o || !out_clk_o || !masked_o) seen++;
            @(negedge clk_i);
        end
        follow_i = 1'b0; master_tick_i = 1'b0; ext_clk_i = 1'b0;
        chk(seen == 0, "R2", seen, 0);
    endtask

    task automatic t_ref;
        int hits = 0;
        wr(cfg(0, 0, 1));
        chk(masked_o == 1'b0, "R2", masked_o, 0);
        for (int i = 0; i < 10; i++) begin
            if (tick_o && !out_clk_o) hits++;
            @(negedge clk_i);
        end
        chk(hits == 10, "R3", hits, 10);
        chk(range_err_o == 1'b0, "R6", range_err_o, 0);
    endtask

    task automatic t_half;
        wr(cfg(0, 0, 2));
        period_check("R4", 2, 8);
    endtask

    task automatic t_pow2;
        wr(cfg(0, 3, 3));
        chk(range_err_o == 1'b0, "R6", range_err_o, 0);
        period_check("R5", 8, 16);
        wr(cfg(0, 4, 3));
        period_check("R5", 16, 32);
    endtask

    task automatic t_range;
        wr(cfg(0, 0, 3));
        chk(range_err_o == 1'b1, "R6", range_err_o, 1);
        period_check("R6", 8, 16);
        wr(cfg(0, 31, 3));
        chk(range_err_o == 1'b1, "R6", range_err_o, 1);
        period_check("R6", 8, 8);
        wr(cfg(0, 2, 2));
        chk(range_err_o == 1'b0, "R6", range_err_o, 0);
    endtask

    task automatic t_ext;
        int ticks = 0, pairs = 0;
        bit prev = 1'b0;
        wr(cfg(0, 0, 0));
        for (int i = 0; i < 30; i++) begin
            ext_clk_i = (i < 24) && ((i % 8) >= 4);
            if (tick_o) ticks++;
            if (tick_o && prev) pairs++;
            prev = tick_o;
            @(negedge clk_i);
        end
        chk(ticks == 3, "R7", ticks, 3);
        chk(pairs == 0, "R7", pairs, 0);
    endtask

    task automatic t_follow;
        int bad = 0;
        wr(cfg(0, 0, 1));
        follow_i = 1'b1;
        @(negedge clk_i);
        for (int i = 0; i < 8; i++) begin
            master_tick_i = (i % 3) == 0;
            #1;
            if (tick_o != master_tick_i) bad++;
            @(negedge clk_i);
        end
        chk(bad == 0, "R8", bad, 0);
        master_tick_i = 1'b0;
        follow_i = 1'b0;
        @(negedge clk_i);
        chk(tick_o == 1'b1, "R8", tick_o, 1);
    endtask

    task automatic t_freeze;
        int wait_n = 0;
        int early = 0;
        wr(cfg(0, 3, 3));
        for (int i = 0; i < 3; i++) begin
            if (tick_o) early++;
            if (i < 2) @(negedge clk_i);
        end
        follow_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk_i);
            if (tick_o) early++;
        end
        follow_i = 1'b0;
        @(negedge clk_i);
        while (!tick_o && wait_n < 20) begin
            wait_n++;
            @(negedge clk_i);
        end
        chk(early == 0, "R9", early, 0);
        chk(wait_n + 1 == 5, "R9", wait_n + 1, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_halt();
        t_ref();
        t_half();
        t_pow2();
        t_range();
        t_ext();
        t_follow();
        t_freeze();
        wr(cfg(1, 0, 0));
        chk(masked_o == 1'b1, "R2", masked_o, 1);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule